// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Register Bank

This block is an I2C target that gives a host access to a small bank of byte-wide registers. Its 7-bit device address is a fixed five-bit prefix followed by two strap inputs, so four copies can share one bus. SCL is only sampled, never driven. SDA is open-drain: the block has a single pull-low enable. Both lines pass through a synchronizer clocked by the system clock, and START, STOP and the SCL edges are detected from the synchronized samples.

In a write transfer, the first byte after the device address loads an internal pointer. Each later byte goes to the register the pointer selects. A read transfer returns bytes from the pointer onward. After every data byte the pointer steps up by one, except when it holds 00h. Location 00h returns a status value on reads and acts only as the pointer target on writes. Locations 01h and 02h return error and version values from the side port. Locations 03h through 19h are read/write and drive parallel outputs. Any location above 19h ignores writes and reads as FFh.

The controller has nine named states. IDLE waits for START. ADDR shifts in the address byte. ADDR_ACK acknowledges a matching address. PTR receives the pointer byte, PTR_ACK acknowledges it, WDATA receives a write byte and WDATA_ACK acknowledges it. RDATA shifts a byte out, and RDATA_ACK samples the host's acknowledge.

The transitions are:
- START leads from any state to ADDR.
- STOP leads from any state to IDLE.
- ADDR goes to ADDR_ACK on a match, or to IDLE on a mismatch, at the SCL fall after the eighth bit.
- ADDR_ACK goes to RDATA for a read or to PTR for a write.
- PTR goes to PTR_ACK, and PTR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RDATA_ACK after eight bits.
- RDATA_ACK goes back to RDATA after a host ACK, or to IDLE after a NACK.

Top module: `i2c_ptr_regfile`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal 0,1,1,0,1,strap[1],strap[0] (bit 0 is read=1/write=0). A transfer with any other address gets no acknowledge and changes no register.
- R2: Bits move most significant first, in both the write and the read direction.
- R3: In a write transfer, the first byte after the address loads the pointer. Each following byte is written to the register the pointer selects.
- R4: After every data byte written or read, the pointer advances by one. This includes bytes written to read-only or invalid locations. It does not advance while the pointer is 00h.
- R5: While the pointer is 00h, every read returns the status input and every data write is acknowledged with no effect.
- R6: A read that has no pointer byte in the same transfer starts at the current pointer, which is the value last loaded plus any advances. This also holds across a repeated START.
- R7: The map is as follows. 00h reads `stat_i`, 01h reads `err_i` and 02h reads `ver_i`. 03h is `ctrl_o`, 04h is `ackh_o`, 05h is `ackl_o` and 06h is `cfg_o`. Locations 07h to 19h are `data_o`, with location 07h+k at bits [8k+7:8k]. Each read/write location reads back its last written value.
- R8: Writes to 00h–02h and to locations above 19h are acknowledged but change no register. Reads above 19h return FFh.
- R9: The block pulls SDA low in the acknowledge slot of a matching address and of every written byte. In a read it drives the data bits and, after a host NACK, releases SDA until the next START. It never pulls SDA low while receiving bits.
- R10: After reset the pointer is 00h, every read/write register is 00h, and SDA is released.
- R11: A START or repeated START clears the bit count, and the next byte is taken as a device address. A STOP in the middle of a byte returns to idle without writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Low two bits of the device address |
| stat_i | input | 8 | Status value, read at 00h |
| err_i | input | 8 | Error value, read at 01h |
| ver_i | input | 8 | Version value, read at 02h |
| ctrl_o | output | 8 | Control register (03h) |
| ackh_o | output | 8 | Acknowledge-high register (04h) |
| ackl_o | output | 8 | Acknowledge-low register (05h) |
| cfg_o | output | 8 | Configuration register (06h) |
| data_o | output | 152 | Data registers 07h..19h, packed lowest location first |

## Verification
The checker watches several properties on every clock:
- SDA is never pulled low while the controller is receiving bits or is idle.
- The pointer only holds or steps by one, except when a pointer byte is taken.
- A pointer of 00h stays at 00h.
- The parallel outputs change only in the cycle after an accepted write.
- Writes aimed at read-only or out-of-range locations leave every output unchanged.

Some behaviour can only be shown by the bench's transfers:
- address matching against the straps;
- bit order;
- the side-port values returned by reads;
- FFh above the map;
- the pointer carried across transfers and repeated STARTs;
- an abandoned byte after a START or STOP in the middle of a byte.

// File: rtl/i2c_prf_pkg.sv
package i2c_prf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } prf_state_e;

    localparam logic [7:0] LOC_STAT  = 8'h00;
    localparam logic [7:0] LOC_ERR   = 8'h01;
    localparam logic [7:0] LOC_VER   = 8'h02;
    localparam logic [7:0] LOC_CTRL  = 8'h03;
    localparam logic [7:0] LOC_ACKH  = 8'h04;
    localparam logic [7:0] LOC_ACKL  = 8'h05;
    localparam logic [7:0] LOC_CFG   = 8'h06;
    localparam logic [7:0] LOC_DATA0 = 8'h07;

    // Pointer advance rule: location zero is sticky.
    function automatic logic [7:0] ptr_step(input logic [7:0] p);
        return (p == 8'h00) ? 8'h00 : p + 8'h01;
    endfunction

endpackage

// File: rtl/prf_line_sync.sv
module prf_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    always_comb begin
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
        sda_lvl   = sda_now;
    end

endmodule

// File: rtl/prf_target_fsm.sv
module prf_target_fsm
    import i2c_prf_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b01101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_i,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_lvl,
    input  logic [7:0] rd_data,
    output prf_state_e state_o,
    output logic [7:0] ptr_o,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    prf_state_e state_q, state_d;
    logic [3:0] bcnt_q;
    logic [7:0] shift_q;
    logic [7:0] tx_q;
    logic [7:0] ptr_q;
    logic       rw_q;
    logic       host_ack_q;
    logic       byte_done;
    logic       addr_hit;
    logic       receiving;

    assign byte_done = (bcnt_q == 4'd8);
    assign addr_hit  = (shift_q[7:1] == {DEV_PREFIX, strap_i});
    assign receiving = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bcnt_q == 4'd7) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_d = host_ack_q ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q     <= '0;
            shift_q    <= '0;
            tx_q       <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bcnt_q <= '0;
            end else if (scl_rise && receiving && !byte_done) begin
                shift_q <= {shift_q[6:0], sda_lvl};
                bcnt_q  <= bcnt_q + 4'd1;
            end else if (scl_rise && state_q == ST_RDATA_ACK) begin
                host_ack_q <= ~sda_lvl;
            end else if (scl_fall) begin
                case (state_q)
                    ST_ADDR: if (byte_done) rw_q <= shift_q[0];
                    ST_ADDR_ACK: begin
                        bcnt_q <= '0;
                        if (rw_q) tx_q <= rd_data;
                    end
                    ST_PTR: if (byte_done) ptr_q <= shift_q;
                    ST_PTR_ACK, ST_WDATA_ACK: bcnt_q <= '0;
                    ST_WDATA: if (byte_done) begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr_q;
                        wr_data <= shift_q;
                        ptr_q   <= ptr_step(ptr_q);
                    end
                    ST_RDATA: begin
                        if (bcnt_q == 4'd7) begin
                            ptr_q <= ptr_step(ptr_q);
                        end else begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            bcnt_q <= bcnt_q + 4'd1;
                        end
                    end
                    ST_RDATA_ACK: begin
                        bcnt_q <= '0;
                        tx_q   <= rd_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_q[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign ptr_o   = ptr_q;

endmodule

// File: rtl/prf_reg_store.sv
module prf_reg_store
    import i2c_prf_pkg::*;
#(
    parameter int LAST_LOC = 'h19,
    localparam int DATA_W  = (LAST_LOC - 6) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    input  logic [7:0]        stat_i,
    input  logic [7:0]        err_i,
    input  logic [7:0]        ver_i,
    output logic [7:0]        rd_data,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        ackh_o,
    output logic [7:0]        ackl_o,
    output logic [7:0]        cfg_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int FIRST_RW = int'(LOC_CTRL);
    localparam int NRW      = LAST_LOC - FIRST_RW + 1;
    localparam int NDATA    = LAST_LOC - int'(LOC_DATA0) + 1;
    localparam int DOFS     = int'(LOC_DATA0) - FIRST_RW;

    logic [7:0] rw_q [NRW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NRW; i++) rw_q[i] <= 8'h00;
        end else if (wr_en) begin
            for (int i = 0; i < NRW; i++)
                if (wr_addr == 8'(FIRST_RW + i)) rw_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_addr == LOC_STAT)     rd_data = stat_i;
        else if (rd_addr == LOC_ERR) rd_data = err_i;
        else if (rd_addr == LOC_VER) rd_data = ver_i;
        else begin
            for (int i = 0; i < NRW; i++)
                if (rd_addr == 8'(FIRST_RW + i)) rd_data = rw_q[i];
        end
    end

    assign ctrl_o = rw_q[int'(LOC_CTRL) - FIRST_RW];
    assign ackh_o = rw_q[int'(LOC_ACKH) - FIRST_RW];
    assign ackl_o = rw_q[int'(LOC_ACKL) - FIRST_RW];
    assign cfg_o  = rw_q[int'(LOC_CFG)  - FIRST_RW];

    generate
        for (genvar k = 0; k < NDATA; k++) begin : g_data
            assign data_o[k*8 +: 8] = rw_q[DOFS + k];
        end
    endgenerate

endmodule

// File: rtl/i2c_ptr_regfile.sv
module i2c_ptr_regfile
    import i2c_prf_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX  = 5'b01101,
    parameter int         LAST_LOC    = 'h19,
    parameter int         SYNC_STAGES = 2,
    localparam int        DATA_W      = (LAST_LOC - 6) * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic [7:0]        stat_i,
    input  logic [7:0]        err_i,
    input  logic [7:0]        ver_i,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        ackh_o,
    output logic [7:0]        ackl_o,
    output logic [7:0]        cfg_o,
    output logic [DATA_W-1:0] data_o
);

    logic       scl_rise_w, scl_fall_w, start_w, stop_w, sda_lvl_w;
    logic       wr_en_w;
    logic [7:0] wr_addr_w, wr_data_w, ptr_w, rd_data_w;
    prf_state_e state_w;

    prf_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_lvl   (sda_lvl_w)
    );

    prf_target_fsm #(.DEV_PREFIX(DEV_PREFIX)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_lvl   (sda_lvl_w),
        .rd_data   (rd_data_w),
        .state_o   (state_w),
        .ptr_o     (ptr_w),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .sda_oe    (sda_oe_o)
    );

    prf_reg_store #(.LAST_LOC(LAST_LOC)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w),
        .rd_addr (ptr_w),
        .stat_i  (stat_i),
        .err_i   (err_i),
        .ver_i   (ver_i),
        .rd_data (rd_data_w),
        .ctrl_o  (ctrl_o),
        .ackh_o  (ackh_o),
        .ackl_o  (ackl_o),
        .cfg_o   (cfg_o),
        .data_o  (data_o)
    );

endmodule

// File: rtl/i2c_ptr_regfile_chk.sv
module i2c_ptr_regfile_chk
    import i2c_prf_pkg::*;
#(
    parameter int LAST_LOC = 'h19,
    parameter int DATA_W   = 152
) (
    input logic              clk,
    input logic              rst_n,
    input prf_state_e        state,
    input logic [7:0]        ptr,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic              sda_oe,
    input logic [7:0]        ctrl,
    input logic [7:0]        ackh,
    input logic [7:0]        ackl,
    input logic [7:0]        cfg,
    input logic [DATA_W-1:0] data
);

    a_r9_quiet_while_listening: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR || state == ST_PTR ||
         state == ST_WDATA || state == ST_RDATA_ACK) |-> !sda_oe);

    a_r4_ptr_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_PTR) |=> (ptr == $past(ptr) || ptr == $past(ptr) + 8'd1));

    a_r5_zero_ptr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == 8'h00 && state != ST_PTR) |=> (ptr == 8'h00));

    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctrl) && $stable(ackh) && $stable(ackl) &&
                    $stable(cfg) && $stable(data)));

    a_r8_protected_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < LOC_CTRL || wr_addr > 8'(LAST_LOC))) |=>
        ($stable(ctrl) && $stable(ackh) && $stable(ackl) && $stable(cfg) && $stable(data)));

endmodule

bind i2c_ptr_regfile i2c_ptr_regfile_chk #(.LAST_LOC(LAST_LOC), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_w),
    .ptr     (ptr_w),
    .wr_en   (wr_en_w),
    .wr_addr (wr_addr_w),
    .sda_oe  (sda_oe_o),
    .ctrl    (ctrl_o),
    .ackh    (ackh_o),
    .ackl    (ackl_o),
    .cfg     (cfg_o),
    .data    (data_o)
);

// File: tb/i2c_ptr_regfile_tb.sv
module i2c_ptr_regfile_tb;

    localparam int CLK_P = 10;
    localparam int QT    = 8 * CLK_P;
    localparam int DW    = 152;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          m_low = 1'b0;
    logic [1:0]    strap = 2'b01;
    logic [7:0]    stat_v = 8'h96, err_v = 8'h4B, ver_v = 8'h21;
    logic          sda_oe;
    logic          sda_line;
    logic [7:0]    ctrl, ackh, ackl, cfg;
    logic [DW-1:0] data;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_q[$];
    event       got_ev;

    assign sda_line = ~(m_low | sda_oe);

    always #(CLK_P/2) clk = ~clk;

    i2c_ptr_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(strap), .stat_i(stat_v), .err_i(err_v), .ver_i(ver_v),
        .ctrl_o(ctrl), .ackh_o(ackh), .ackl_o(ackl), .cfg_o(cfg), .data_o(data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_start();  m_low = 1'b1; #QT; scl = 1'b0; #QT; endtask
    task automatic bus_rstart(); m_low = 1'b0; #QT; scl = 1'b1; #QT; m_low = 1'b1; #QT; scl = 1'b0; #QT; endtask
    task automatic bus_stop();   m_low = 1'b1; #QT; scl = 1'b1; #QT; m_low = 1'b0; #QT; endtask

    task automatic put_bit(input logic b);
        m_low = ~b; #QT; scl = 1'b1; #(2*QT); scl = 1'b0; #QT;
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; #QT; scl = 1'b1; #QT; b = sda_line; #QT; scl = 1'b0; #QT;
    endtask

    task automatic put_byte(input logic [7:0] v, input string tag, input logic exp_ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        chk(tag, {31'd0, ~b}, {31'd0, exp_ack});
    endtask

    // driver side of the scoreboard: push expectation, then clock the byte in
    task automatic rd_byte(input logic give_ack, input string tag, input logic [7:0] expv);
        logic [7:0] v;
        logic b;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(~give_ack);
        got_q.push_back(v);
        -> got_ev;
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [7:0] p);
        bus_start();
        put_byte({dev, 1'b0}, "R1 address ack", 1'b1);
        put_byte(p, "R9 pointer byte ack", 1'b1);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(got_ev);
            while (got_q.size() != 0) begin
                logic [7:0] a;
                a = got_q.pop_front();
                if (exp_q.size() == 0) chk("R6 unexpected read byte", {24'd0, a}, 32'h100);
                else chk(tag_q.pop_front(), {24'd0, a}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0]    dev;
        logic [DW-1:0] exp_data;
        dev = 7'h35;
        exp_data = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10 reset state
        chk("R10 sda released", {31'd0, sda_oe}, 0);
        chk("R10 ctrl", {24'd0, ctrl}, 0);
        chk("R10 ackh/ackl/cfg", {8'd0, ackh, ackl, cfg}, 0);
        chk("R10 data", {31'd0, data == '0}, 1);

        // R10/R5: pointer starts at 00h, status repeats
        bus_start();
        put_byte({dev, 1'b1}, "R1 read address ack", 1'b1);
        rd_byte(1'b1, "R10 reset pointer reads status", 8'h96);
        rd_byte(1'b0, "R5 status again", 8'h96);
        chk("R9 released after NACK", {31'd0, sda_oe}, 0);
        bus_stop();

        // R3/R4/R7 write ctrl..cfg
        set_ptr(dev, 8'h03);
        put_byte(8'h1E, "R9 data ack", 1'b1);
        put_byte(8'h6C, "R9 data ack", 1'b1);
        put_byte(8'hB4, "R9 data ack", 1'b1);
        put_byte(8'h8F, "R9 data ack", 1'b1);
        bus_stop();
        chk("R3 ctrl written", {24'd0, ctrl}, 32'h1E);
        chk("R4 ackh next", {24'd0, ackh}, 32'h6C);
        chk("R4 ackl next", {24'd0, ackl}, 32'hB4);
        chk("R7 cfg", {24'd0, cfg}, 32'h8F);

        // R2/R11 read back across repeated START
        set_ptr(dev, 8'h03);
        bus_rstart();
        put_byte({dev, 1'b1}, "R11 address after repeated START", 1'b1);
        rd_byte(1'b1, "R2 ctrl readback", 8'h1E);
        rd_byte(1'b1, "R2 ackh readback", 8'h6C);
        rd_byte(1'b1, "R7 ackl readback", 8'hB4);
        rd_byte(1'b0, "R7 cfg readback", 8'h8F);
        bus_stop();

        // R6 read with no pointer byte
        set_ptr(dev, 8'h07);
        put_byte(8'h11, "R9 data ack", 1'b1);
        put_byte(8'h22, "R9 data ack", 1'b1);
        bus_stop();
        exp_data[15:0] = 16'h2211;
        chk("R7 data_o packing", {31'd0, data == exp_data}, 1);
        set_ptr(dev, 8'h07);
        bus_stop();
        bus_start();
        put_byte({dev, 1'b1}, "R1 read address ack", 1'b1);
        rd_byte(1'b1, "R6 last pointer", 8'h11);
        rd_byte(1'b0, "R6 advanced pointer", 8'h22);
        bus_stop();

        // R5 pointer 00h: write ignored, reads status
        set_ptr(dev, 8'h00);
        put_byte(8'h77, "R8 write at 00h acked", 1'b1);
        bus_rstart();
        put_byte({dev, 1'b1}, "R1 read address ack", 1'b1);
        rd_byte(1'b1, "R5 sticky status", 8'h96);
        rd_byte(1'b0, "R5 sticky status", 8'h96);
        bus_stop();
        chk("R5 no register touched", {ctrl, ackh, ackl, cfg}, 32'h1E6CB48F);

        // R7 error and version
        set_ptr(dev, 8'h01);
        bus_rstart();
        put_byte({dev, 1'b1}, "R1 read address ack", 1'b1);
        rd_byte(1'b1, "R7 error", 8'h4B);
        rd_byte(1'b0, "R7 version", 8'h21);
        bus_stop();

        // R8 read-only writes ignored but advance
        set_ptr(dev, 8'h01);
        put_byte(8'hFF, "R8 write 01h acked", 1'b1);
        put_byte(8'hEE, "R8 write 02h acked", 1'b1);
        put_byte(8'h99, "R9 data ack", 1'b1);
        bus_stop();
        chk("R4 advance past read-only", {24'd0, ctrl}, 32'h99);
        chk("R8 ackh untouched", {24'd0, ackh}, 32'h6C);

        // R8 last location and beyond
        set_ptr(dev, 8'h19);
        put_byte(8'hAB, "R9 data ack", 1'b1);
        put_byte(8'hCD, "R8 write 1Ah acked", 1'b1);
        bus_stop();
        exp_data[151:144] = 8'hAB;
        chk("R8 only 19h changed", {31'd0, data == exp_data}, 1);
        set_ptr(dev, 8'h19);
        bus_rstart();
        put_byte({dev, 1'b1}, "R1 read address ack", 1'b1);
        rd_byte(1'b1, "R7 last data location", 8'hAB);
        rd_byte(1'b1, "R8 read 1Ah", 8'hFF);
        rd_byte(1'b0, "R8 read 1Bh", 8'hFF);
        bus_stop();
        set_ptr(dev, 8'h20);
        put_byte(8'h55, "R8 write 20h acked", 1'b1);
        bus_stop();
        chk("R8 20h write inert", {31'd0, data == exp_data}, 1);
        chk("R8 20h write inert regs", {ctrl, ackh, ackl, cfg}, 32'h996CB48F);

        // R1 wrong address
        bus_start();
        put_byte({7'h34, 1'b0}, "R1 foreign address no ack", 1'b0);
        put_byte(8'h03, "R1 no ack after mismatch", 1'b0);
        put_byte(8'h00, "R1 no ack after mismatch", 1'b0);
        bus_stop();
        chk("R1 mismatch no write", {24'd0, ctrl}, 32'h99);

        // R1 other strap setting
        strap = 2'b10;
        dev = 7'h36;
        #QT;
        set_ptr(dev, 8'h03);
        put_byte(8'h42, "R9 data ack", 1'b1);
        bus_stop();
        chk("R1 new strap address", {24'd0, ctrl}, 32'h42);

        // R11 repeated START mid-byte
        set_ptr(dev, 8'h05);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_rstart();
        put_byte({dev, 1'b0}, "R11 byte phase reset", 1'b1);
        put_byte(8'h06, "R9 pointer byte ack", 1'b1);
        put_byte(8'hE7, "R9 data ack", 1'b1);
        bus_stop();
        chk("R11 cfg after restart", {24'd0, cfg}, 32'hE7);
        chk("R11 partial byte dropped", {24'd0, ackl}, 32'hB4);

        // R11 STOP mid-byte
        set_ptr(dev, 8'h04);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        chk("R11 stop drops byte", {24'd0, ackh}, 32'h6C);
        bus_start();
        put_byte({dev, 1'b1}, "R11 idle after STOP", 1'b1);
        rd_byte(1'b0, "R6 pointer kept after STOP", 8'h6C);
        bus_stop();

        repeat (10) @(negedge clk);
        chk("R6 scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule